// File: doc/BRIEF.md
# Clock Output Mode Controller

This block steers a true/complement clock output pair for a differential clock driver. It watches two active-low controls, one for power-down and one for output stop. Both pass through a short synchronizer before a three-way operating state is decoded: running, stopped or powered down.

While the block is running, a three-bit mode word picks what reaches the pair: the phase-aligned clock, the raw synthesizer clock or the reference clock. The mode word can also put the pair into high impedance. The mode word and a two-bit multiplier select are captured only while power-down is in effect. At all other times they are held. The held multiplier select is reported as a numerator/denominator ratio.

Clock sources arrive as plain digital inputs. The pair follows the selected source combinationally. Switching between states is not required to be glitch-free.

Top module: `clkout_mode_ctrl`

## Requirements
- R1: When the synchronized power-down input is low, `op_state` is 2 (powered down) and `out_p`, `out_n` and `out_en` are all 0, whatever the stop input and the mode.
- R2: When the block is running with the stop input synchronized low and a clock mode is held, `op_state` is 1, `out_en` is 1 and both `out_p` and `out_n` equal `STOP_LEVEL` (default 1).
- R3: With power-down and stop both high and mode {S0,S1,S2} = 000 (`mode_sel[2]`=S0, `mode_sel[1]`=S1, `mode_sel[0]`=S2), `out_p` follows `aligned_clk`, `out_n` is its inverse and `out_en` is 1.
- R4: In the same running state, mode 100 routes `pll_clk` to `out_p` and its inverse to `out_n`, with `out_en` at 1.
- R5: In the same running state, mode 110 routes `ref_clk` to `out_p` and its inverse to `out_n`, with `out_en` at 1.
- R6: Mode S0=0, S1=1 (010 or 011) gives the high-impedance case. `out_en` is 0 and both outputs are 0, even while stopped.
- R7: The undefined codes 001, 101 and 111 give `out_en` at 0 and both outputs at 0.
- R8: `mode_sel` and `mult_sel` are loaded only on clock edges at which the synchronized power-down is low. Changes made at any other time have no effect on the outputs or on the ratio.
- R9: The held `mult_sel` ({MULT0,MULT1} = {`mult_sel[1]`,`mult_sel[0]`}) reports its ratio on `mult_num`/`mult_den`. The mapping is 11 → 8/1, 01 → 6/1, 00 → 4/1 and 10 → 8/3.
- R10: While `rst_n` is low, the held configuration is mode 000 with ratio 4/1, and the block reports powered down with all outputs 0.
- R11: A change on `pwrdn_n_in` reaches the outputs after exactly `SYNC_STAGES` (default 2) rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n_in | input | 1 | Active-low power-down request, asynchronous |
| stop_n_in | input | 1 | Active-low output stop request, asynchronous |
| mode_sel | input | 3 | Output mode {S0,S1,S2} |
| mult_sel | input | 2 | Multiplier select {MULT0,MULT1} |
| aligned_clk | input | 1 | Phase-aligned clock source |
| pll_clk | input | 1 | Raw synthesizer clock source |
| ref_clk | input | 1 | Reference clock source |
| out_p | output | 1 | True output |
| out_n | output | 1 | Complement output |
| out_en | output | 1 | Output driver enable; 0 means grounded or high impedance |
| mult_num | output | 4 | Multiplier ratio numerator |
| mult_den | output | 2 | Multiplier ratio denominator |
| op_state | output | 2 | 0 running, 1 stopped, 2 powered down |

## Verification
The bench keeps the defaults: `SYNC_STAGES` = 2 and `STOP_LEVEL` = 1. With a stop level of 1, a stopped pair (both high) can be told apart from a grounded pair and from a pair in high impedance (both low, driver disabled). With two sync stages, the latency check can place a sample exactly between the first and the second edge after power-down falls. A table covers every mode code and every multiplier code through a power-down load. Directed runs then attempt configuration changes while the block is running and check that the outputs and the ratio do not move.

// File: rtl/clkout_mode_ctrl.sv
module clkout_mode_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter bit STOP_LEVEL  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n_in,
  input  logic       stop_n_in,
  input  logic [2:0] mode_sel,
  input  logic [1:0] mult_sel,
  input  logic       aligned_clk,
  input  logic       pll_clk,
  input  logic       ref_clk,
  output logic       out_p,
  output logic       out_n,
  output logic       out_en,
  output logic [3:0] mult_num,
  output logic [1:0] mult_den,
  output logic [1:0] op_state
);

  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_STOP = 2'd1;
  localparam logic [1:0] ST_DOWN = 2'd2;

  logic [SYNC_STAGES-1:0] pd_sync, st_sync;
  logic pd_on, st_on;
  logic [2:0] mode_q;
  logic [1:0] mult_q;
  logic src, muted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sync <= '0;
      st_sync <= '0;
    end else begin
      pd_sync <= {pd_sync[SYNC_STAGES-2:0], pwrdn_n_in};
      st_sync <= {st_sync[SYNC_STAGES-2:0], stop_n_in};
    end
  end

  assign pd_on = pd_sync[SYNC_STAGES-1];
  assign st_on = st_sync[SYNC_STAGES-1];

  assign op_state = !pd_on ? ST_DOWN : (!st_on ? ST_STOP : ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      mult_q <= 2'b00;
    end else if (!pd_on) begin
      mode_q <= mode_sel;
      mult_q <= mult_sel;
    end
  end

  always_comb begin
    case (mult_q)
      2'b11:   begin mult_num = 4'd8; mult_den = 2'd1; end
      2'b01:   begin mult_num = 4'd6; mult_den = 2'd1; end
      2'b10:   begin mult_num = 4'd8; mult_den = 2'd3; end
      default: begin mult_num = 4'd4; mult_den = 2'd1; end
    endcase
  end

  always_comb begin
    src   = 1'b0;
    muted = 1'b0;
    case (mode_q)
      3'b000:  src = aligned_clk;
      3'b100:  src = pll_clk;
      3'b110:  src = ref_clk;
      default: muted = 1'b1;
    endcase
  end

  always_comb begin
    if (op_state == ST_DOWN || muted) begin
      out_p  = 1'b0;
      out_n  = 1'b0;
      out_en = 1'b0;
    end else if (op_state == ST_STOP) begin
      out_p  = STOP_LEVEL;
      out_n  = STOP_LEVEL;
      out_en = 1'b1;
    end else begin
      out_p  = src;
      out_n  = ~src;
      out_en = 1'b1;
    end
  end

endmodule

// File: rtl/clkout_mode_ctrl_chk.sv
module clkout_mode_ctrl_chk #(
  parameter bit STOP_LEVEL = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrdn_n_in,
  input logic       pd_on,
  input logic [2:0] mode_q,
  input logic       out_p,
  input logic       out_n,
  input logic       out_en,
  input logic [3:0] mult_num,
  input logic [1:0] mult_den,
  input logic [1:0] op_state
);

  AST_PD_GROUND: assert property (@(posedge clk) disable iff (!rst_n)
    op_state == 2'd2 |-> (!out_p && !out_n && !out_en)); // R1

  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 2'd1 && out_en) |-> (out_p == STOP_LEVEL && out_n == STOP_LEVEL)); // R2

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 2'd0 && out_en) |-> (out_n != out_p)); // R3

  AST_HIZ_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:1] == 2'b01) |-> !out_en); // R6

  AST_UNDEF_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b001 || mode_q == 3'b101 || mode_q == 3'b111) |-> !out_en); // R7

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_on) |-> ($stable(mode_q) && $stable(mult_num) && $stable(mult_den))); // R8

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_den == 2'd1 && (mult_num == 4'd4 || mult_num == 4'd6 || mult_num == 4'd8)) ||
    (mult_den == 2'd3 && mult_num == 4'd8)); // R9

  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwrdn_n_in, 2) |-> op_state == 2'd2); // R11

endmodule

bind clkout_mode_ctrl clkout_mode_ctrl_chk #(.STOP_LEVEL(STOP_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrdn_n_in(pwrdn_n_in), .pd_on(pd_on),
  .mode_q(mode_q), .out_p(out_p), .out_n(out_n), .out_en(out_en),
  .mult_num(mult_num), .mult_den(mult_den), .op_state(op_state)
);

// File: tb/clkout_mode_ctrl_test.sv
module clkout_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_n_in = 1'b1, stop_n_in = 1'b1;
  logic [2:0] mode_sel = 3'b000;
  logic [1:0] mult_sel = 2'b00;
  logic aligned_clk = 1'b0, pll_clk = 1'b0, ref_clk = 1'b0;
  logic out_p, out_n, out_en;
  logic [3:0] mult_num;
  logic [1:0] mult_den;
  logic [1:0] op_state;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkout_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n_in(pwrdn_n_in), .stop_n_in(stop_n_in),
    .mode_sel(mode_sel), .mult_sel(mult_sel), .aligned_clk(aligned_clk),
    .pll_clk(pll_clk), .ref_clk(ref_clk), .out_p(out_p), .out_n(out_n),
    .out_en(out_en), .mult_num(mult_num), .mult_den(mult_den), .op_state(op_state)
  );

  // mode, mult, stop_n, {aligned,pll,ref}, {exp_p,exp_n,exp_en}, num, den
  localparam logic [17:0] VECS [13] = '{
    {3'b000, 2'b11, 1'b1, 3'b100, 3'b101, 4'd8, 2'd1},  // R3 R9
    {3'b000, 2'b11, 1'b1, 3'b011, 3'b011, 4'd8, 2'd1},  // R3
    {3'b100, 2'b01, 1'b1, 3'b010, 3'b101, 4'd6, 2'd1},  // R4 R9
    {3'b100, 2'b00, 1'b1, 3'b101, 3'b011, 4'd4, 2'd1},  // R4 R9
    {3'b110, 2'b10, 1'b1, 3'b001, 3'b101, 4'd8, 2'd3},  // R5 R9
    {3'b110, 2'b10, 1'b1, 3'b110, 3'b011, 4'd8, 2'd3},  // R5
    {3'b010, 2'b00, 1'b1, 3'b111, 3'b000, 4'd4, 2'd1},  // R6
    {3'b011, 2'b11, 1'b1, 3'b111, 3'b000, 4'd8, 2'd1},  // R6
    {3'b001, 2'b11, 1'b1, 3'b111, 3'b000, 4'd8, 2'd1},  // R7
    {3'b101, 2'b01, 1'b1, 3'b111, 3'b000, 4'd6, 2'd1},  // R7
    {3'b111, 2'b10, 1'b1, 3'b111, 3'b000, 4'd8, 2'd3},  // R7
    {3'b000, 2'b01, 1'b0, 3'b100, 3'b111, 4'd6, 2'd1},  // R2
    {3'b010, 2'b11, 1'b0, 3'b000, 3'b000, 4'd8, 2'd1}   // R6 over stop
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ticks(3);
    chk("R10 outputs", {5'd0, out_p, out_n, out_en}, 8'h00);
    chk("R10 ratio", {2'd0, mult_den, mult_num}, {2'd0, 2'd1, 4'd4});
    chk("R1 state in reset", {6'd0, op_state}, 8'd2);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      pwrdn_n_in = 1'b0;
      mode_sel = VECS[i][17:15];
      mult_sel = VECS[i][14:13];
      ticks(4);
      pwrdn_n_in = 1'b1;
      stop_n_in = VECS[i][12];
      {aligned_clk, pll_clk, ref_clk} = VECS[i][11:9];
      ticks(4);
      #1;
      chk($sformatf("R2-7 vec %0d outputs", i), {5'd0, out_p, out_n, out_en}, {5'd0, VECS[i][8:6]});
      chk($sformatf("R9 vec %0d ratio", i), {2'd0, mult_den, mult_num}, {2'd0, VECS[i][1:0], VECS[i][5:2]});
    end

    // R8: load aligned mode, x6, then try to change config while running
    pwrdn_n_in = 1'b0; stop_n_in = 1'b1; mode_sel = 3'b000; mult_sel = 2'b01;
    ticks(4);
    pwrdn_n_in = 1'b1;
    ticks(4);
    mode_sel = 3'b110; mult_sel = 2'b10;
    aligned_clk = 1'b1; ref_clk = 1'b0;
    ticks(5);
    #1;
    chk("R8 output source held", {5'd0, out_p, out_n, out_en}, 8'b101);
    chk("R8 ratio held", {2'd0, mult_den, mult_num}, {2'd0, 2'd1, 4'd6});
    aligned_clk = 1'b0;
    #1;
    chk("R8 follows aligned", {5'd0, out_p, out_n, out_en}, 8'b011);

    // R11: latency of power-down
    mode_sel = 3'b000; mult_sel = 2'b01;
    aligned_clk = 1'b1;
    pwrdn_n_in = 1'b0;
    ticks(1);
    chk("R11 after one edge", {5'd0, out_p, out_n, out_en}, 8'b101);
    ticks(1);
    chk("R11 after two edges", {5'd0, out_p, out_n, out_en}, 8'b000);
    chk("R1 state", {6'd0, op_state}, 8'd2);

    // R1: power-down overrides stop
    stop_n_in = 1'b0;
    ticks(4);
    chk("R1 with stop low", {5'd0, out_p, out_n, out_en}, 8'b000);
    chk("R1 state with stop", {6'd0, op_state}, 8'd2);
    pwrdn_n_in = 1'b1;
    ticks(4);
    chk("R2 state stopped", {6'd0, op_state}, 8'd1);
    chk("R2 stop level", {5'd0, out_p, out_n, out_en}, 8'b111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule